// File: doc/BRIEF.md
# Sign-Magnitude Floating-Point Adder-Subtractor

This block adds or subtracts two packed floating-point operands of the same precision. The format is sign-magnitude with an excess-256 exponent and a hidden leading one. Each operand is unpacked: the leading one is restored, a guard bit is appended and the bias is removed. The block then deals with zero operands and with swamping, aligns the operand with the smaller exponent, and combines the two mantissas.

The result is an unnormalized unpacked value: a 57-bit mantissa that includes a carry position, a signed exponent, a sign and the precision flag. It is meant to feed a separate normalize-round-pack stage. The block does not normalize, round or raise traps.

Each accepted request gives a registered result one clock later. Subtraction flips the sign of the second operand and then adds.

Top module: `fpAddSub`

## Requirements
- R1: `outValid` is high in the cycle after a cycle in which `inValid` is high, and low otherwise. The result outputs change only on a clock edge where `inValid` is high, and otherwise keep their values.
- R2: Packed layout of a 64-bit operand:
  - bit 63 is the sign, bits 62:54 are the biased exponent, and bits 53:0 are the fraction.
  - In single precision (`precDouble`=0) only fraction bits 53:32 count, and bits 31:0 are ignored.
  - Unpacked mantissa: bit 56 is the carry, bit 55 the restored leading one, bits 54:1 the fraction (54:33 in single precision), and bit 0 the guard bit.
  - The unpacked exponent is the field minus 256, as 10-bit two's complement.
- R3: An operand is zero when its exponent field and its counted fraction bits are all zero, whatever its sign bit. Any other operand, including one with a zero exponent field and a nonzero fraction, gets the leading one restored.
- R4: If both operands are zero, the result is mantissa 0, exponent -256 (10'h300) and sign positive.
- R5: If exactly one operand is zero, the result is the unpacked form of the other operand. For a subtraction, a nonzero second operand comes out with its sign inverted.
- R6: Subtraction (`opSub`=1) gives the same result as an addition with the sign bit of the second operand inverted.
- R7: If the exponent gap is above 23 (single) or above 55 (double), the result is the unpacked operand with the larger exponent, and nothing is added. A gap exactly equal to the limit is still added.
- R8: Otherwise the mantissa with the smaller exponent is shifted right by the gap, and bits below the guard bit are lost. The result exponent is the larger exponent. With equal exponents the first operand is the one shifted, by zero.
- R9: With equal signs the aligned mantissas are added and the common sign is kept. The sum may set bit 56.
- R10: With different signs the smaller aligned mantissa is subtracted from the larger, and the result takes the larger one's sign. If the magnitudes are equal, the result is zero with the first operand's sign.
- R11: During and right after reset, `outValid` and all result outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request strobe; operands are taken on this edge |
| opSub | input | 1 | 1 = subtract second operand from first, 0 = add |
| precDouble | input | 1 | 1 = double precision (54-bit fraction), 0 = single (22-bit) |
| opA | input | 64 | First packed operand |
| opB | input | 64 | Second packed operand |
| outValid | output | 1 | Result strobe, one cycle after `inValid` |
| resMant | output | 57 | Unnormalized mantissa with carry, leading one and guard bit |
| resExp | output | 10 | Unbiased result exponent, two's complement |
| resNeg | output | 1 | Result sign, 1 = negative |
| resDouble | output | 1 | Precision of the result |

## Verification
The bench builds the block with its default parameters: a 9-bit exponent, a 54-bit double fraction and a 22-bit single fraction. With these defaults the two swamp limits are 23 and 55. Gaps of exactly the limit and one more can be driven in both precisions, and a gap of 30 is driven in double precision, where single precision would have swamped it. The 64-bit operand also lets the bench put nonzero values in the low word of a single-precision operand, to show that those bits are ignored.

// File: rtl/fpasPkg.sv
package fpasPkg;
  localparam int EXP_W      = 9;
  localparam int FRAC_W     = 54;
  localparam int SGL_FRAC_W = 22;
  localparam int BIAS       = 256;
  localparam int OPND_W     = 1 + EXP_W + FRAC_W;
  localparam int MANT_W     = FRAC_W + 3;
  localparam int UEXP_W     = EXP_W + 1;

  typedef struct packed {
    logic [MANT_W-1:0] mant;
    logic [UEXP_W-1:0] expo;
    logic              neg;
    logic              zero;
  } fpasUnp_t;

  typedef struct packed {
    logic load;
    logic sub;
    logic dbl;
  } fpasCtl_t;
endpackage

// File: rtl/fpasUnpack.sv
module fpasUnpack
  import fpasPkg::*;
#(
  parameter int P_EXP_W      = EXP_W,
  parameter int P_FRAC_W     = FRAC_W,
  parameter int P_SGL_FRAC_W = SGL_FRAC_W,
  parameter int P_BIAS       = BIAS
) (
  input  logic [P_EXP_W+P_FRAC_W:0] opnd,
  input  logic                      dbl,
  output fpasUnp_t                  unp
);
  localparam int OW = P_EXP_W + P_FRAC_W + 1;
  localparam logic [P_FRAC_W-1:0] SGL_MASK =
    {{P_SGL_FRAC_W{1'b1}}, {(P_FRAC_W-P_SGL_FRAC_W){1'b0}}};

  logic [P_EXP_W-1:0]  expField;
  logic [P_FRAC_W-1:0] frac;
  logic                isZero;

  always_comb begin
    expField = opnd[OW-2 -: P_EXP_W];
    frac     = dbl ? opnd[P_FRAC_W-1:0] : (opnd[P_FRAC_W-1:0] & SGL_MASK);
    isZero   = (expField == '0) && (frac == '0);
    unp.mant = isZero ? '0 : {1'b0, 1'b1, frac, 1'b0};
    unp.expo = {1'b0, expField} - UEXP_W'(P_BIAS);
    unp.neg  = isZero ? 1'b0 : opnd[OW-1];
    unp.zero = isZero;
  end
endmodule

// File: rtl/fpasControl.sv
module fpasControl
  import fpasPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     inValid,
  input  logic     opSub,
  input  logic     precDouble,
  output fpasCtl_t ctl,
  output logic     outValid
);
  always_comb begin
    ctl.load = inValid;
    ctl.sub  = opSub;
    ctl.dbl  = precDouble;
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= ctl.load;
  end

  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  assert_valid_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
endmodule

// File: rtl/fpasDatapath.sv
module fpasDatapath
  import fpasPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  fpasCtl_t          ctl,
  input  logic [OPND_W-1:0] opA,
  input  logic [OPND_W-1:0] opB,
  output logic [MANT_W-1:0] resMant,
  output logic [UEXP_W-1:0] resExp,
  output logic              resNeg,
  output logic              resDouble
);
  localparam int DW      = UEXP_W + 1;
  localparam int SGL_LIM = SGL_FRAC_W + 1;
  localparam int DBL_LIM = FRAC_W + 1;

  fpasUnp_t          unp [2];
  logic [OPND_W-1:0] opnds [2];

  assign opnds[0] = opA;
  assign opnds[1] = opB;

  for (genvar gi = 0; gi < 2; gi++) begin : gUnpack
    fpasUnpack uUnp (.opnd(opnds[gi]), .dbl(ctl.dbl), .unp(unp[gi]));
  end

  logic              negB;
  logic [DW-1:0]     expDiff;
  logic [DW-1:0]     absDiff;
  logic              aBigger;
  logic              swamped;
  logic [MANT_W-1:0] shA, shB;
  logic [UEXP_W-1:0] bigExp;
  logic [MANT_W-1:0] nxtMant;
  logic [UEXP_W-1:0] nxtExp;
  logic              nxtNeg;

  always_comb begin
    negB    = unp[1].neg ^ ctl.sub;
    expDiff = {unp[0].expo[UEXP_W-1], unp[0].expo} - {unp[1].expo[UEXP_W-1], unp[1].expo};
    absDiff = expDiff[DW-1] ? (~expDiff + DW'(1)) : expDiff;
    aBigger = !expDiff[DW-1] && (expDiff != '0);
    swamped = absDiff > (ctl.dbl ? DW'(DBL_LIM) : DW'(SGL_LIM));
    shA     = aBigger ? unp[0].mant : (unp[0].mant >> absDiff);
    shB     = aBigger ? (unp[1].mant >> absDiff) : unp[1].mant;
    bigExp  = aBigger ? unp[0].expo : unp[1].expo;

    if (unp[0].zero && unp[1].zero) begin
      nxtMant = '0;
      nxtExp  = UEXP_W'(-BIAS);
      nxtNeg  = 1'b0;
    end else if (unp[1].zero) begin
      nxtMant = unp[0].mant; nxtExp = unp[0].expo; nxtNeg = unp[0].neg;
    end else if (unp[0].zero) begin
      nxtMant = unp[1].mant; nxtExp = unp[1].expo; nxtNeg = negB;
    end else if (swamped) begin
      nxtMant = aBigger ? unp[0].mant : unp[1].mant;
      nxtExp  = bigExp;
      nxtNeg  = aBigger ? unp[0].neg : negB;
    end else begin
      nxtExp = bigExp;
      if (unp[0].neg == negB) begin
        nxtMant = shA + shB;
        nxtNeg  = negB;
      end else if (shB > shA) begin
        nxtMant = shB - shA;
        nxtNeg  = negB;
      end else begin
        nxtMant = shA - shB;
        nxtNeg  = unp[0].neg;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resMant   <= '0;
      resExp    <= '0;
      resNeg    <= 1'b0;
      resDouble <= 1'b0;
    end else if (ctl.load) begin
      resMant   <= nxtMant;
      resExp    <= nxtExp;
      resNeg    <= nxtNeg;
      resDouble <= ctl.dbl;
    end
  end

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.load |=> $stable(resMant) && $stable(resExp) && $stable(resNeg));

  assert_both_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load && unp[0].zero && unp[1].zero |=> (resMant == '0) && !resNeg);

  assert_result_exp_max_R8: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load && !unp[0].zero && !unp[1].zero |=>
      ($signed(resExp) >= $signed($past(unp[0].expo))) &&
      ($signed(resExp) >= $signed($past(unp[1].expo))));

  assert_same_sign_lead_R9: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load && !unp[0].zero && !unp[1].zero && (unp[0].neg == (unp[1].neg ^ ctl.sub))
      |=> resMant[MANT_W-1] || resMant[MANT_W-2]);

  assert_no_carry_diff_R10: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load && !unp[0].zero && !unp[1].zero && (unp[0].neg != (unp[1].neg ^ ctl.sub))
      |=> !resMant[MANT_W-1]);
endmodule

// File: rtl/fpAddSub.sv
module fpAddSub
  import fpasPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              opSub,
  input  logic              precDouble,
  input  logic [OPND_W-1:0] opA,
  input  logic [OPND_W-1:0] opB,
  output logic              outValid,
  output logic [MANT_W-1:0] resMant,
  output logic [UEXP_W-1:0] resExp,
  output logic              resNeg,
  output logic              resDouble
);
  fpasCtl_t ctl;

  fpasControl uCtl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opSub(opSub),
    .precDouble(precDouble), .ctl(ctl), .outValid(outValid)
  );

  fpasDatapath uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .opA(opA), .opB(opB),
    .resMant(resMant), .resExp(resExp), .resNeg(resNeg), .resDouble(resDouble)
  );
endmodule

// File: tb/fpAddSub_test.sv
module fpAddSub_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        opSub = 1'b0;
  logic        precDouble = 1'b0;
  logic [63:0] opA = '0;
  logic [63:0] opB = '0;
  logic        outValid;
  logic [56:0] resMant;
  logic [9:0]  resExp;
  logic        resNeg;
  logic        resDouble;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fpAddSub uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opSub(opSub), .precDouble(precDouble),
    .opA(opA), .opB(opB), .outValid(outValid), .resMant(resMant), .resExp(resExp),
    .resNeg(resNeg), .resDouble(resDouble)
  );

  function automatic logic [63:0] sOp(logic s, logic [8:0] e, logic [21:0] f);
    return {s, e, f, 32'h0};
  endfunction
  function automatic logic [63:0] dOp(logic s, logic [8:0] e, logic [53:0] f);
    return {s, e, f};
  endfunction
  function automatic logic [56:0] sM(logic [21:0] f);
    return {2'b01, f, 33'b0};
  endfunction

  typedef struct packed {
    logic        sub;
    logic        dbl;
    logic [63:0] a;
    logic [63:0] b;
    logic [56:0] mant;
    logic [9:0]  expo;
    logic        neg;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, sOp(0, 256, 0), sOp(0, 256, 0), {2'b10, 55'b0}, 10'd0, 1'b0},                  // R9 carry
    '{1'b1, 1'b0, sOp(0, 256, 0), sOp(0, 256, 0), 57'h0, 10'd0, 1'b0},                            // R6 R10 equal
    '{1'b1, 1'b0, sOp(1, 256, 0), sOp(1, 256, 0), 57'h0, 10'd0, 1'b1},                            // R10 first sign
    '{1'b0, 1'b0, sOp(0, 258, 0), sOp(0, 256, 22'h200000), sM(22'h180000), 10'd2, 1'b0},          // R8 align
    '{1'b0, 1'b0, sOp(0, 256, 0), sOp(1, 256, 22'h200000), 57'h1 << 54, 10'd0, 1'b1},             // R10 b larger
    '{1'b0, 1'b0, sOp(1, 256, 22'h200000), sOp(0, 256, 0), 57'h1 << 54, 10'd0, 1'b1},             // R10 a larger
    '{1'b0, 1'b0, sOp(1, 300, 1), sOp(0, 256, 0), sM(22'h1), 10'd44, 1'b1},                       // R7 swamp a
    '{1'b0, 1'b0, sOp(0, 279, 0), sOp(0, 256, 0), (57'h1 << 55) | (57'h1 << 32), 10'd23, 1'b0},   // R7 gap 23
    '{1'b1, 1'b0, sOp(0, 256, 0), sOp(0, 280, 5), sM(22'h5), 10'd24, 1'b1},                       // R7 R6 gap 24
    '{1'b0, 1'b1, dOp(0, 311, 0), dOp(0, 256, 0), (57'h1 << 55) | 57'h1, 10'd55, 1'b0},           // R7 dbl gap 55
    '{1'b0, 1'b1, dOp(0, 256, 3), dOp(1, 312, 0), 57'h1 << 55, 10'd56, 1'b1},                     // R7 dbl gap 56
    '{1'b0, 1'b1, dOp(0, 286, 0), dOp(0, 256, 0), (57'h1 << 55) | (57'h1 << 25), 10'd30, 1'b0},   // R7 R8 dbl gap 30
    '{1'b1, 1'b0, sOp(0, 0, 0), sOp(0, 256, 22'h200000), sM(22'h200000), 10'd0, 1'b1},            // R5 a zero
    '{1'b0, 1'b0, sOp(1, 0, 0), sOp(0, 0, 0), 57'h0, 10'h300, 1'b0},                              // R4 R3 neg zero
    '{1'b1, 1'b0, sOp(1, 256, 0), sOp(1, 0, 0), 57'h1 << 55, 10'd0, 1'b1},                        // R5 R3 b neg zero
    '{1'b0, 1'b0, sOp(0, 256, 0) | 64'hDEADBEEF, 64'hFFFFFFFF, 57'h1 << 55, 10'd0, 1'b0},         // R2 low word ignored
    '{1'b0, 1'b0, sOp(0, 0, 1), sOp(0, 0, 2), (57'h1 << 56) | (57'h1 << 34) | (57'h1 << 33), 10'h300, 1'b0}, // R3 R2
    '{1'b0, 1'b1, dOp(0, 256, 1), dOp(0, 256, 1), (57'h1 << 56) | 57'h4, 10'd0, 1'b0},            // R2 dbl lsb
    '{1'b0, 1'b0, sOp(0, 257, 0), sOp(0, 256, 1), (57'h1 << 55) | (57'h1 << 54) | (57'h1 << 32), 10'd1, 1'b0} // R8 shift
  };

  task automatic check(string req, logic [63:0] act, logic [63:0] expv);
    tests++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11 reset outValid", 64'(outValid), 64'h0);
    check("R11 reset resMant", 64'(resMant), 64'h0);
    check("R11 reset resExp", 64'(resExp), 64'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R11 after reset outValid", 64'(outValid), 64'h0);
    check("R11 after reset resNeg", 64'(resNeg), 64'h0);

    for (int i = 0; i < NV; i++) begin
      opSub = VECS[i].sub;
      precDouble = VECS[i].dbl;
      opA = VECS[i].a;
      opB = VECS[i].b;
      inValid = 1'b1;
      @(negedge clk);
      inValid = 1'b0;
      check($sformatf("R1 vec%0d outValid", i), 64'(outValid), 64'h1);
      check($sformatf("R2-path vec%0d mant", i), 64'(resMant), 64'(VECS[i].mant));
      check($sformatf("R8 vec%0d expo", i), 64'(resExp), 64'(VECS[i].expo));
      check($sformatf("R10 vec%0d sign", i), 64'(resNeg), 64'(VECS[i].neg));
      check($sformatf("R2 vec%0d precision", i), 64'(resDouble), 64'(VECS[i].dbl));
    end

    // R1: idle cycles with new operands leave the last result untouched
    opA = sOp(0, 400, 22'h3FFFFF);
    opB = sOp(1, 10, 0);
    opSub = 1'b1;
    precDouble = 1'b1;
    @(negedge clk);
    check("R1 idle outValid", 64'(outValid), 64'h0);
    @(negedge clk);
    check("R1 hold mant", 64'(resMant), 64'(VECS[NV-1].mant));
    check("R1 hold expo", 64'(resExp), 64'(VECS[NV-1].expo));
    check("R1 hold precision", 64'(resDouble), 64'h0);

    // R6: subtract equals add with second sign inverted
    opA = sOp(0, 260, 22'h012345);
    opB = sOp(0, 258, 22'h0ABCDE);
    opSub = 1'b1;
    precDouble = 1'b0;
    inValid = 1'b1;
    @(negedge clk);
    begin
      logic [56:0] m1;
      logic [9:0]  e1;
      logic        n1;
      m1 = resMant; e1 = resExp; n1 = resNeg;
      opB = sOp(1, 258, 22'h0ABCDE);
      opSub = 1'b0;
      @(negedge clk);
      inValid = 1'b0;
      check("R6 sub vs add mant", 64'(resMant), 64'(m1));
      check("R6 sub vs add expo", 64'(resExp), 64'(e1));
      check("R6 sub vs add sign", 64'(resNeg), 64'(n1));
    end

    // R11: reset mid-stream clears outputs
    rstN = 1'b0;
    @(negedge clk);
    check("R11 re-reset mant", 64'(resMant), 64'h0);
    check("R11 re-reset valid", 64'(outValid), 64'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule